// File: doc/BRIEF.md
# Sliding-Scale Ring Oscillator TDC Coarse Encoder

This block is the synchronous back end of a ring-oscillator time-to-digital converter. It does not model delay cells. It drives the enable of a ring of delay stages and, while the ring is stopped, the preset word the ring starts from. It counts ring revolutions from a wrap pulse. On an asynchronous STOP it takes the flip-flop snapshot of the ring stages and turns the phase pattern and revolution count into one interval code, in units of one stage delay.

Every conversion starts the ring at a different phase. A linear-feedback shift register chooses that phase, and the block subtracts it from the raw code. This sliding scale spreads the mismatch of individual delay cells across all output codes. With the defaults there are four stages, giving eight phases, and a two-bit revolution counter, so the code is five bits wide and spans 32 steps. Each extra counter bit doubles the range.

Top module: `ring_tdc_coarse`

## Requirements
- R1: After reset the ring enable, the result-valid flag, the error flag and the code are all 0. The preset shows the pattern for start index 1, which is 0001 with the default seed of 1.
- R2: The preset follows the twisted-ring pattern of the start index: index 0..7 maps to 0000, 0001, 0011, 0111, 1111, 1110, 1100, 1000, with bit 0 as the rightmost bit. The preset does not change while the ring is enabled.
- R3: A start pulse seen while idle raises the ring enable at the next rising edge. A start pulse while the ring runs, or while a result is held, has no effect.
- R4: Each clock cycle with the wrap pulse high, while the ring is enabled, adds 1 to the revolution counter, modulo 2^CNT_W (4 by default). The counter clears at start.
- R5: STOP passes a two-flop synchronizer. If STOP is first high at rising edge E0, the result-valid flag is still low after E0 and E1. The flag rises and the ring enable falls at E2.
- R6: The code is (8 × revolutions + phase index − start index) mod 32. The phase index is the position of the captured ring pattern in the R2 sequence.
- R7: A captured ring pattern that is not in the R2 sequence raises the error flag together with result-valid, and phase index 0 is used.
- R8: The start index is the low 3 bits of a 7-bit register seeded with 1. At each capture edge it steps to {q[5:0], q[6] xor q[5]}.
- R9: The result-valid flag and the code hold until an acknowledge. The flag is low at the edge after the acknowledge, and the block is then idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start conversion pulse (synchronous) |
| stop_i | input | 1 | Stop event, asynchronous level |
| wrap_i | input | 1 | One pulse per ring revolution (synchronous) |
| ring_state_i | input | STAGES | Sampled ring stage outputs |
| ack_i | input | 1 | Result read acknowledge |
| ring_en_o | output | 1 | Ring oscillator enable |
| ring_preset_o | output | STAGES | Ring starting state, applied while disabled |
| valid_o | output | 1 | Result held and valid |
| code_o | output | CNT_W+3 | Offset-corrected interval code |
| phase_err_o | output | 1 | Captured ring pattern was illegal |

## Verification
A wrong start-index register shows up at the preset port before every conversion. It then shows up in the code of that same conversion, because the offset is subtracted there. A miscounted revolution or a wrong phase decode changes the code by a multiple of 8 or by a fixed phase amount at the capture edge, two cycles after STOP is synchronized. A broken control state shows as a start pulse that is not ignored, or as a valid flag that drops without an acknowledge, within one clock.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RUN  = 2'd1,
      ST_HOLD = 2'd2
   } rtc_state_t;
endpackage

// File: rtl/rtc_sync2.sv
module rtc_sync2 (
   input  logic clk,
   input  logic rst_n,
   input  logic async_i,
   output logic sync_o
);
   logic meta_q, sync_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         meta_q <= 1'b0;
         sync_q <= 1'b0;
      end else begin
         meta_q <= async_i;
         sync_q <= meta_q;
      end
   end

   assign sync_o = sync_q;
endmodule

// File: rtl/rtc_lfsr.sv
module rtc_lfsr #(
   parameter int              WIDTH = 7,
   parameter logic [WIDTH-1:0] SEED = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step_i,
   output logic [WIDTH-1:0] q_o
);
   logic [WIDTH-1:0] q;
   logic             fb;

   if (SEED == '0) begin : g_bad_seed
      $error("rtc_lfsr: seed must be nonzero");
   end

   if (WIDTH == 5) begin : g_w5
      assign fb = q[4] ^ q[2];
   end else if (WIDTH == 6) begin : g_w6
      assign fb = q[5] ^ q[4];
   end else if (WIDTH == 7) begin : g_w7
      assign fb = q[6] ^ q[5];
   end else begin : g_bad_w
      assign fb = 1'b0;
      $error("rtc_lfsr: WIDTH must be 5, 6 or 7");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      q <= SEED;
      else if (step_i) q <= {q[WIDTH-2:0], fb};
   end

   assign q_o = q;
endmodule

// File: rtl/rtc_phase_map.sv
module rtc_phase_map #(
   parameter int STAGES = 4,
   localparam int NPH  = 2 * STAGES,
   localparam int PH_W = $clog2(NPH)
) (
   input  logic [PH_W-1:0]   idx_i,
   output logic [STAGES-1:0] pattern_o,
   input  logic [STAGES-1:0] sample_i,
   output logic [PH_W-1:0]   phase_o,
   output logic              illegal_o
);
   function automatic logic [STAGES-1:0] twist_pat(input int i);
      logic [STAGES-1:0] p;
      for (int b = 0; b < STAGES; b++) begin
         if (i < STAGES) p[b] = (b < i);
         else            p[b] = (b >= i - STAGES);
      end
      return p;
   endfunction

   logic [NPH-1:0] hit;

   for (genvar g = 0; g < NPH; g++) begin : g_cmp
      assign hit[g] = (sample_i == twist_pat(g));
   end

   always_comb begin
      pattern_o = '0;
      for (int i = 0; i < NPH; i++) begin
         if (idx_i == PH_W'(i)) pattern_o = twist_pat(i);
      end
   end

   always_comb begin
      phase_o = '0;
      for (int i = 0; i < NPH; i++) begin
         if (hit[i]) phase_o = PH_W'(i);
      end
   end

   assign illegal_o = (hit == '0);
endmodule

// File: rtl/ring_tdc_coarse.sv
module ring_tdc_coarse #(
   parameter int STAGES    = 4,
   parameter int CNT_W     = 2,
   parameter int LFSR_W    = 7,
   parameter int LFSR_SEED = 1,
   localparam int PH_W     = $clog2(2 * STAGES),
   localparam int CODE_W   = CNT_W + PH_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              stop_i,
   input  logic              wrap_i,
   input  logic [STAGES-1:0] ring_state_i,
   input  logic              ack_i,
   output logic              ring_en_o,
   output logic [STAGES-1:0] ring_preset_o,
   output logic              valid_o,
   output logic [CODE_W-1:0] code_o,
   output logic              phase_err_o
);
   import rtc_pkg::*;

   if (STAGES < 2 || (1 << PH_W) != 2 * STAGES) begin : g_bad_stages
      $error("ring_tdc_coarse: STAGES must be a power of two, at least 2");
   end
   if (CNT_W < 1) begin : g_bad_cnt
      $error("ring_tdc_coarse: CNT_W must be at least 1");
   end
   if (LFSR_W < PH_W) begin : g_bad_lfsr
      $error("ring_tdc_coarse: LFSR narrower than phase index");
   end

   rtc_state_t       state_q;
   logic [CNT_W-1:0] rev_q;
   logic [PH_W-1:0]  offs_q;
   logic [CODE_W-1:0] code_q;
   logic             err_q;
   logic             stop_s;
   logic             capture;
   logic [LFSR_W-1:0] lfsr_q;
   logic [PH_W-1:0]  phase;
   logic             illegal;
   logic [CODE_W-1:0] raw;

   rtc_sync2 u_stop_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_i (stop_i),
      .sync_o  (stop_s)
   );

   assign capture = (state_q == ST_RUN) && stop_s;

   rtc_lfsr #(
      .WIDTH (LFSR_W),
      .SEED  (LFSR_W'(LFSR_SEED))
   ) u_lfsr (
      .clk    (clk),
      .rst_n  (rst_n),
      .step_i (capture),
      .q_o    (lfsr_q)
   );

   rtc_phase_map #(
      .STAGES (STAGES)
   ) u_map (
      .idx_i     (lfsr_q[PH_W-1:0]),
      .pattern_o (ring_preset_o),
      .sample_i  (ring_state_i),
      .phase_o   (phase),
      .illegal_o (illegal)
   );

   assign raw = {rev_q, (illegal ? {PH_W{1'b0}} : phase)};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         rev_q   <= '0;
         offs_q  <= '0;
         code_q  <= '0;
         err_q   <= 1'b0;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               if (start_i) begin
                  state_q <= ST_RUN;
                  rev_q   <= '0;
                  offs_q  <= lfsr_q[PH_W-1:0];
               end
            end
            ST_RUN: begin
               if (capture) begin
                  state_q <= ST_HOLD;
                  code_q  <= raw - CODE_W'(offs_q);
                  err_q   <= illegal;
               end else if (wrap_i) begin
                  rev_q <= rev_q + 1'b1;
               end
            end
            ST_HOLD: begin
               if (ack_i) begin
                  state_q <= ST_IDLE;
                  err_q   <= 1'b0;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign ring_en_o   = (state_q == ST_RUN);
   assign valid_o     = (state_q == ST_HOLD);
   assign code_o      = code_q;
   assign phase_err_o = err_q;
endmodule

// File: rtl/ring_tdc_coarse_chk.sv
module ring_tdc_coarse_chk #(
   parameter int STAGES = 4,
   parameter int CODE_W = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start_i,
   input logic              ack_i,
   input logic              ring_en_o,
   input logic [STAGES-1:0] ring_preset_o,
   input logic              valid_o,
   input logic [CODE_W-1:0] code_o,
   input logic              phase_err_o
);
   p_preset_frozen_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ring_en_o && $past(ring_en_o) |-> $stable(ring_preset_o));

   p_busy_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o && start_i && !ack_i |=> valid_o && !ring_en_o);

   p_valid_from_run_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(valid_o) |-> $past(ring_en_o));

   p_run_no_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ring_en_o |-> !valid_o);

   p_err_with_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
      phase_err_o |-> valid_o);

   p_valid_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o && !ack_i |=> valid_o && $stable(code_o) && $stable(phase_err_o));

   p_ack_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o && ack_i |=> !valid_o);
endmodule

bind ring_tdc_coarse ring_tdc_coarse_chk #(
   .STAGES (STAGES),
   .CODE_W (CODE_W)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .start_i       (start_i),
   .ack_i         (ack_i),
   .ring_en_o     (ring_en_o),
   .ring_preset_o (ring_preset_o),
   .valid_o       (valid_o),
   .code_o        (code_o),
   .phase_err_o   (phase_err_o)
);

// File: tb/ring_tdc_coarse_test.sv
`timescale 1ns/1ps
module ring_tdc_coarse_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start_i = 1'b0, stop_i = 1'b0, wrap_i = 1'b0, ack_i = 1'b0;
   logic [3:0] ring_state_i = 4'b0000;
   logic       ring_en_o, valid_o, phase_err_o;
   logic [3:0] ring_preset_o;
   logic [4:0] code_o;

   int checks = 0;
   int failures = 0;
   logic [6:0] lfsr_m = 7'h01;

   always #5 clk = ~clk;

   ring_tdc_coarse uut (
      .clk (clk), .rst_n (rst_n), .start_i (start_i), .stop_i (stop_i),
      .wrap_i (wrap_i), .ring_state_i (ring_state_i), .ack_i (ack_i),
      .ring_en_o (ring_en_o), .ring_preset_o (ring_preset_o),
      .valid_o (valid_o), .code_o (code_o), .phase_err_o (phase_err_o)
   );

   function automatic logic [3:0] pat(input int i);
      case (i)
         0: return 4'b0000; 1: return 4'b0001; 2: return 4'b0011; 3: return 4'b0111;
         4: return 4'b1111; 5: return 4'b1110; 6: return 4'b1100; default: return 4'b1000;
      endcase
   endfunction

   function automatic logic [4:0] exp_code(input int revs, input int ph, input int s);
      return 5'(((revs % 4) * 8 + ph - s + 64) % 32);
   endfunction

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic step;
      @(negedge clk);
   endtask

   // one full conversion; ph < 0 means illegal pattern 0101
   task automatic convert(input int revs, input int ph, input bit busy_start);
      int s;
      s = int'(lfsr_m[2:0]);
      check("R2 preset pattern", ring_preset_o, pat(s));
      start_i = 1'b1; step; start_i = 1'b0;
      check("R3 enable after start", ring_en_o, 1);
      for (int k = 0; k < revs; k++) begin
         wrap_i = 1'b1;
         if (busy_start && k == 0) start_i = 1'b1;
         step;
         start_i = 1'b0;
      end
      wrap_i = 1'b0;
      ring_state_i = (ph < 0) ? 4'b0101 : pat(ph);
      stop_i = 1'b1; step;
      check("R5 no valid after E0", valid_o, 0);
      step;
      check("R5 no valid after E1", valid_o, 0);
      step;
      stop_i = 1'b0;
      check("R5 valid at E2", valid_o, 1);
      check("R5 enable drops", ring_en_o, 0);
      check("R6 code", code_o, exp_code(revs, (ph < 0) ? 0 : ph, s));
      check("R7 error flag", phase_err_o, (ph < 0) ? 1 : 0);
      lfsr_m = {lfsr_m[5:0], lfsr_m[6] ^ lfsr_m[5]};
      check("R8 next start index", ring_preset_o, pat(int'(lfsr_m[2:0])));
      start_i = 1'b1; step; start_i = 1'b0;
      check("R3 start ignored while held", ring_en_o, 0);
      check("R9 valid held", valid_o, 1);
      check("R9 code held", code_o, exp_code(revs, (ph < 0) ? 0 : ph, s));
      ack_i = 1'b1; step; ack_i = 1'b0;
      check("R9 released by ack", valid_o, 0);
      step; step;
   endtask

   initial begin
      #2_000_000;
      failures++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      void'($urandom(32'd4711));
      step; step;
      check("R1 reset enable", ring_en_o, 0);
      check("R1 reset valid", valid_o, 0);
      check("R1 reset error", phase_err_o, 0);
      check("R1 reset code", code_o, 0);
      check("R1 reset preset", ring_preset_o, 4'b0001);
      rst_n = 1'b1;
      step;
      // R6 directed: zero revolutions, phase 0 below the start offset wraps
      convert(0, 0, 1'b0);
      // R4 counter wraps modulo 4
      convert(5, 3, 1'b0);
      // R3 start while running does not clear the counter
      convert(2, 6, 1'b1);
      // R7 illegal pattern
      convert(1, -1, 1'b0);
      // R6 top of range
      convert(3, 7, 1'b0);
      for (int n = 0; n < 40; n++) begin
         int r, p;
         r = int'($urandom_range(0, 6));
         p = int'($urandom_range(0, 7));
         if ($urandom_range(0, 9) == 0) p = -1;
         convert(r, p, $urandom_range(0, 3) == 0);
      end
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule